// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block sits between a simple request port and the column-command side of a single-data-rate SDRAM. Each accepted request becomes one READ or WRITE column command of one beat. The rows are assumed to be open already. Reads may be issued on every clock, so a run of reads returns a continuous stream of data. The CAS latency is set to 2 or 3 clocks by a static configuration input.

The main job of the block is the switch from reading to writing. A WRITE may cut off read data that is still in flight. To allow this, the sequencer holds the WRITE back and raises the data mask (DQM) so that it is high on each of the two clocks before the WRITE. Any read beat that would meet the write data on the bus is masked in this way. A configuration input can also demand one clean idle cycle between the last unmasked read beat and the WRITE. Beats that are masked or cut off are dropped. Beats that still come back are delivered one cycle after they appear on the bus, with a valid strobe.

Top module: `sdr_turn_seq`

## Requirements
- R1: After reset, `cmd` is NOP, and `dqm`, `dqOe` and `rdValid` are low. With no write offered, `reqReady` is high. The command codes are NOP=2'b00, READ=2'b01 and WRITE=2'b10.
- R2: An offered read is always accepted. It drives READ on `cmd` in the same cycle, with `cmdBank` and `cmdCol` taken from the request. Reads may follow each other on consecutive cycles.
- R3: A READ issued in cycle t has its data sampled from `dqIn` in cycle t+CL, where CL is 2 when `casLat3`=0 and 3 when `casLat3`=1. That data appears on `rdData` with `rdValid` high in cycle t+CL+1, and beats come out in issue order.
- R4: A write offered with no read data pending is issued in the same cycle, unless R7 blocks it. In the WRITE cycle, `dqOe` is high, `dqOut` equals `reqWdata` and `dqm` is low.
- R5: A write that would cut off pending read data is issued only if `dqm` was high in each of the two previous cycles. While a write is held back, `dqm` is high, `reqReady` is low and `cmd` is NOP.
- R6: A read beat whose bus cycle is two cycles after a cycle with `dqm` high never raises `rdValid`.
- R7: With `gapEn`=1, no WRITE is issued in the cycle directly after a cycle that carried an unmasked read beat.
- R8: With `gapEn`=0, a WRITE may be issued in the cycle directly after an unmasked read beat, as soon as R5 allows it.
- R9: `dqOe` is high only in cycles that issue a WRITE, and never in a cycle that carries an unmasked read beat.
- R10: A read offered in the cycle right after a WRITE is issued in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| casLat3 | input | 1 | CAS latency select: 0 gives 2 clocks, 1 gives 3 clocks. Change only while idle |
| gapEn | input | 1 | Demand one idle bus cycle between the last unmasked read beat and a WRITE |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted in this cycle |
| reqWrite | input | 1 | 1 for a write request, 0 for a read request |
| reqBank | input | BANK_W | Bank of the request |
| reqCol | input | COL_W | Column of the request |
| reqWdata | input | DATA_W | Write data |
| cmd | output | 2 | Column command: NOP, READ or WRITE |
| cmdBank | output | BANK_W | Bank of the command |
| cmdCol | output | COL_W | Column of the command |
| dqm | output | 1 | Data mask to the memory |
| dqOut | output | DATA_W | Write data driven to the bus |
| dqOe | output | 1 | Output enable of the controller's data driver |
| dqIn | input | DATA_W | Data read from the bus |
| rdValid | output | 1 | A returned read beat is on `rdData` |
| rdData | output | DATA_W | Returned read data |

## Verification
The sharp case is the cycle in which a held-back write is raising the mask while an earlier read beat, too late to be masked, is still landing on the bus and must be delivered. The bench provokes this by offering a write right behind one, two or three reads, at both latencies and with the gap rule on and off. In every stalled cycle it checks that the mask is high and the command is NOP. It checks that the WRITE comes after exactly the expected number of stall cycles, and it counts how many read beats still reach `rdValid`. Because masked beats must vanish while earlier unmasked ones survive, a slip of a single cycle in the mask alignment changes that count.

// File: rtl/sdr_turn_pkg.sv
package sdr_turn_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10
  } sdrCmdE;

  // strobes from control into the datapath
  typedef struct packed {
    logic issueRd;
    logic issueWr;
    logic maskHi;
  } ctrlStrobeT;

  // read-pipeline status back to control
  typedef struct packed {
    logic pendAny;   // some read beat still due on the bus (masked or not)
    logic liveNow;   // an unmasked read beat is on the bus this cycle
  } pipeStatT;

endpackage

// File: rtl/turn_ctrl.sv
module turn_ctrl
  import sdr_turn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gapEn,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  pipeStatT   stat,
  output ctrlStrobeT strobe,
  output logic       reqReady,
  output logic       dqm
);

  logic dqmD1;      // mask level one cycle ago
  logic dqmD2;      // mask level two cycles ago
  logic prevLive;   // unmasked read beat on the bus last cycle
  logic leadOk;
  logic gapOk;
  logic allowWr;
  logic wrBlocked;

  // cutting off pending read data needs the mask up on both previous clocks
  assign leadOk    = !stat.pendAny || (dqmD1 && dqmD2);
  assign gapOk     = !(gapEn && prevLive);
  assign allowWr   = leadOk && gapOk;
  assign wrBlocked = reqValid && reqWrite && !allowWr;

  assign reqReady       = !(reqWrite && !allowWr);
  assign strobe.issueRd = reqValid && !reqWrite;
  assign strobe.issueWr = reqValid && reqWrite && allowWr;
  assign strobe.maskHi  = wrBlocked;
  assign dqm            = wrBlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqmD1    <= 1'b0;
      dqmD2    <= 1'b0;
      prevLive <= 1'b0;
    end else begin
      dqmD1    <= dqm;
      dqmD2    <= dqmD1;
      prevLive <= stat.liveNow;
    end
  end

  AST_STALL_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |-> (!strobe.issueRd && !strobe.issueWr)); // R5

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.issueRd && strobe.issueWr)); // R2

endmodule

// File: rtl/turn_datapath.sv
module turn_datapath
  import sdr_turn_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COL_W   = 10,
  parameter int BANK_W  = 2,
  parameter int CL_HI   = 3,
  parameter int DQM_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              casLat3,
  input  logic              gapEn,
  input  ctrlStrobeT        strobe,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dqIn,
  output sdrCmdE            cmdE,
  output logic [BANK_W-1:0] cmdBank,
  output logic [COL_W-1:0]  cmdCol,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output pipeStatT          stat
);

  localparam int CL_LO = CL_HI - 1;
  localparam int IDX_W = (CL_HI > 1) ? $clog2(CL_HI) : 1;

  // slot i in cycle c stands for a read beat due on the bus in cycle c+i
  logic [CL_HI-1:0] beatVld;
  logic [CL_HI-1:0] beatLive;
  logic [CL_HI-1:0] nxtVld;
  logic [CL_HI-1:0] nxtLive;
  logic [IDX_W-1:0] insIdx;

  assign insIdx = casLat3 ? IDX_W'(CL_HI - 1) : IDX_W'(CL_LO - 1);

  always_comb begin
    nxtVld  = '0;
    nxtLive = '0;
    for (int i = 0; i < CL_HI - 1; i++) begin
      nxtVld[i]  = beatVld[i + 1];
      nxtLive[i] = beatLive[i + 1];
    end
    // mask now kills the beat due DQM_LAT cycles ahead
    if (strobe.maskHi) nxtLive[DQM_LAT - 1] = 1'b0;
    if (strobe.issueRd) begin
      nxtVld[insIdx]  = 1'b1;
      nxtLive[insIdx] = 1'b1;
    end
    // a registered WRITE cuts off whatever is still due
    if (strobe.issueWr) begin
      nxtVld  = '0;
      nxtLive = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatVld  <= '0;
      beatLive <= '0;
    end else begin
      beatVld  <= nxtVld;
      beatLive <= nxtLive;
    end
  end

  assign stat.pendAny = |beatVld;
  assign stat.liveNow = beatLive[0];

  // capture of returning read data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= beatLive[0];
      if (beatLive[0]) rdData <= dqIn;
    end
  end

  // command and write-data drive
  always_comb begin
    if (strobe.issueWr)      cmdE = CMD_WRITE;
    else if (strobe.issueRd) cmdE = CMD_READ;
    else                     cmdE = CMD_NOP;
  end

  assign cmdBank = reqBank;
  assign cmdCol  = reqCol;
  assign dqOe    = strobe.issueWr;
  assign dqOut   = strobe.issueWr ? reqWdata : '0;

  AST_WR_LEAD_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueWr && stat.pendAny) |-> ($past(strobe.maskHi) && $past(strobe.maskHi, 2))); // R5

  AST_WR_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueWr |-> !strobe.maskHi); // R4

  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (gapEn && strobe.issueWr) |-> !$past(beatLive[0])); // R7

  AST_OE_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !beatLive[0]); // R9

endmodule

// File: rtl/sdr_turn_seq.sv
module sdr_turn_seq
  import sdr_turn_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COL_W   = 10,
  parameter int BANK_W  = 2,
  parameter int CL_HI   = 3,
  parameter int DQM_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              casLat3,
  input  logic              gapEn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [1:0]        cmd,
  output logic [BANK_W-1:0] cmdBank,
  output logic [COL_W-1:0]  cmdCol,
  output logic              dqm,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  input  logic [DATA_W-1:0] dqIn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  ctrlStrobeT strobe;
  pipeStatT   stat;
  sdrCmdE     cmdE;

  turn_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .gapEn    (gapEn),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .stat     (stat),
    .strobe   (strobe),
    .reqReady (reqReady),
    .dqm      (dqm)
  );

  turn_datapath #(
    .DATA_W  (DATA_W),
    .COL_W   (COL_W),
    .BANK_W  (BANK_W),
    .CL_HI   (CL_HI),
    .DQM_LAT (DQM_LAT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .casLat3  (casLat3),
    .gapEn    (gapEn),
    .strobe   (strobe),
    .reqBank  (reqBank),
    .reqCol   (reqCol),
    .reqWdata (reqWdata),
    .dqIn     (dqIn),
    .cmdE     (cmdE),
    .cmdBank  (cmdBank),
    .cmdCol   (cmdCol),
    .dqOut    (dqOut),
    .dqOe     (dqOe),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .stat     (stat)
  );

  assign cmd = cmdE;

endmodule

// File: tb/test_sdr_turn_seq.sv
module test_sdr_turn_seq;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] C_NOP = 2'b00, C_RD = 2'b01, C_WR = 2'b10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        casLat3 = 1'b0, gapEn = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0]  reqBank = '0;
  logic [9:0]  reqCol = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, dqm, dqOe, rdValid;
  logic [1:0]  cmd, cmdBank;
  logic [9:0]  cmdCol;
  logic [31:0] dqOut, rdData, dqIn;
  logic [31:0] cyc = '0;
  int          nChecks = 0, nFails = 0;
  bit          done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign dqIn = {16'hDA7A, cyc[15:0]};

  sdr_turn_seq i_sdr_turn_seq (
    .clk(clk), .rstN(rstN), .casLat3(casLat3), .gapEn(gapEn),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqCol(reqCol), .reqWdata(reqWdata),
    .cmd(cmd), .cmdBank(cmdBank), .cmdCol(cmdCol), .dqm(dqm),
    .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn),
    .rdValid(rdValid), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic nextCycle();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      nextCycle();
      reqValid = 1'b0;
      reqWrite = 1'b0;
    end
  endtask

  // R1: state after reset
  task automatic runReset();
    #1;
    check("R1 cmd", 32'(cmd), 32'(C_NOP));
    check("R1 dqm", 32'(dqm), 0);
    check("R1 dqOe", 32'(dqOe), 0);
    check("R1 rdValid", 32'(rdValid), 0);
    check("R1 reqReady", 32'(reqReady), 1);
  endtask

  // R2 and R3: four back-to-back reads
  task automatic runReads(input logic cl3);
    int          cl;
    logic [31:0] first, prevC;
    cl = cl3 ? 3 : 2;
    casLat3 = cl3;
    first = '0;
    for (int k = 0; k < 4; k++) begin
      nextCycle();
      reqValid = 1'b1; reqWrite = 1'b0;
      reqBank = 2'(k); reqCol = 10'(16 + k);
      #1;
      if (k == 0) first = cyc;
      check("R2 read cmd", 32'(cmd), 32'(C_RD));
      check("R2 read col", 32'(cmdCol), 32'(16 + k));
      check("R2 read bank", 32'(cmdBank), 32'(k));
      check("R2 read ready", 32'(reqReady), 1);
    end
    for (int k = 0; k < 8; k++) begin
      nextCycle();
      reqValid = 1'b0;
      #1;
      prevC = cyc - 1;
      if (cyc >= first + 32'(cl) + 1 && cyc <= first + 32'(cl) + 4) begin
        check("R3 rdValid", 32'(rdValid), 1);
        check("R3 rdData", rdData, {16'hDA7A, prevC[15:0]});
      end else begin
        check("R3 rdValid idle", 32'(rdValid), 0);
      end
    end
  endtask

  // R4..R10: reads, idle gap, then a write, then a read right after it
  task automatic runCut(input string tag, input logic cl3, input logic gap,
                        input int nRd, input int nIdle, input int expDelay, input int expLive);
    int          waited, liveSeen;
    logic [31:0] wd;
    casLat3 = cl3; gapEn = gap;
    wd = 32'hC0DE_0000 + 32'(nRd * 16 + nIdle) + (cl3 ? 32'h100 : 0) + (gap ? 32'h1000 : 0);
    liveSeen = 0;
    for (int k = 0; k < nRd; k++) begin
      nextCycle();
      reqValid = 1'b1; reqWrite = 1'b0; reqCol = 10'(k);
      #1;
      liveSeen += int'(rdValid);
    end
    for (int k = 0; k < nIdle; k++) begin
      nextCycle();
      reqValid = 1'b0;
      #1;
      liveSeen += int'(rdValid);
    end
    nextCycle();
    reqValid = 1'b1; reqWrite = 1'b1; reqWdata = wd; reqCol = 10'd77; reqBank = 2'd3;
    #1;
    waited = 0;
    while (!reqReady && waited < 8) begin
      liveSeen += int'(rdValid);
      check({tag, " R5 dqm high while held"}, 32'(dqm), 1);
      check({tag, " R5 NOP while held"}, 32'(cmd), 32'(C_NOP));
      check({tag, " R9 no oe while held"}, 32'(dqOe), 0);
      waited++;
      nextCycle();
      #1;
    end
    liveSeen += int'(rdValid);
    check({tag, " R5/R7/R8 stall cycles"}, 32'(waited), 32'(expDelay));
    check({tag, " R4 write cmd"}, 32'(cmd), 32'(C_WR));
    check({tag, " R4 write col"}, 32'(cmdCol), 32'd77);
    check({tag, " R4 dqm low on write"}, 32'(dqm), 0);
    check({tag, " R9 oe on write"}, 32'(dqOe), 1);
    check({tag, " R4 write data"}, dqOut, wd);
    nextCycle();
    reqValid = 1'b1; reqWrite = 1'b0; reqCol = 10'd5;
    #1;
    liveSeen += int'(rdValid);
    check({tag, " R10 read after write"}, 32'(cmd), 32'(C_RD));
    check({tag, " R10 ready"}, 32'(reqReady), 1);
    check({tag, " R9 oe off on read"}, 32'(dqOe), 0);
    for (int k = 0; k < 7; k++) begin
      nextCycle();
      reqValid = 1'b0;
      #1;
      liveSeen += int'(rdValid);
    end
    check({tag, " R6 delivered beats"}, 32'(liveSeen), 32'(expLive + 1));
  endtask

  initial begin
    runReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    runReset();
    runReads(1'b0);
    idle(3);
    runReads(1'b1);
    idle(3);
    runCut("idle write", 1'b0, 1'b1, 0, 0, 0, 0);
    idle(3);
    runCut("cl3 gap two reads", 1'b1, 1'b1, 2, 0, 3, 1);
    idle(3);
    runCut("cl3 nogap two reads", 1'b1, 1'b0, 2, 0, 2, 1);
    idle(3);
    runCut("cl2 gap one read", 1'b0, 1'b1, 1, 0, 3, 1);
    idle(3);
    runCut("cl2 nogap one read", 1'b0, 1'b0, 1, 0, 2, 1);
    idle(3);
    runCut("cl3 nogap three reads", 1'b1, 1'b0, 3, 0, 2, 2);
    idle(3);
    runCut("cl3 gap three reads", 1'b1, 1'b1, 3, 0, 3, 2);
    idle(3);
    runCut("cl2 gap late write", 1'b0, 1'b1, 1, 2, 1, 1);
    idle(3);
    runCut("cl2 nogap late write", 1'b0, 1'b0, 1, 2, 0, 1);
    idle(3);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule